// File: doc/BRIEF.md
# Parallel EEPROM Byte Write Master

This block is a synchronous bus master for a byte-wide parallel EEPROM. It takes a single-byte request (address, data, read or write) over a valid/ready handshake. It then drives the chip-select, write-strobe and output-enable lines, all active low, plus the address and data bus. For reads, it returns the sampled byte. For writes, it reports completion of the device's internal programming without any fixed delay.

All timing is counted in clock cycles and set by parameters:

- setup time before the write strobe falls,
- write strobe low width,
- hold time after the strobe rises,
- read access time,
- output-enable gap between status reads,
- completion timeout.

Write completion is confirmed in one of two ways, chosen per request. In ready/busy mode the block watches a ready/busy input. In polling mode it reads the written address again and again until bit 7 of the read byte equals bit 7 of the written byte. If completion is not seen within the timeout, the response carries a timeout flag.

Top module: `eeprom_byte_master`

## Requirements
- R1: During and right after reset, `mem_ce_n`, `mem_we_n` and `mem_oe_n` are high, `mem_drv` is low, `req_ready` is high and `rsp_valid` is low.
- R2: In a write, `mem_ce_n` is low and `mem_oe_n` is high for the whole strobe. `mem_ce_n` is low with `mem_we_n` high for at least SETUP_CYC cycles before `mem_we_n` falls. `mem_addr` stays stable while `mem_we_n` is low. At the cycle where `mem_we_n` rises, `mem_drv` is high and `mem_dout` carries the request data.
- R3: `mem_we_n` stays low for exactly WE_PULSE_CYC cycles per write. It then rises while `mem_ce_n` stays low and the data stays driven for HOLD_CYC cycles.
- R4: In ready/busy mode (`poll_mode` = 0 at acceptance), the block first waits for `mem_rdy` to be seen low and then high. It then gives a one-cycle `rsp_valid` with `rsp_timeout` = 0 and `rsp_data` equal to the written byte. No output-enable pulse is issued.
- R5: In polling mode (`poll_mode` = 1 at acceptance), the block repeats read accesses to the written address. In each access `mem_oe_n` is low for exactly ACC_CYC cycles. Between accesses `mem_oe_n` is high for at least GAP_CYC cycles. The write completes when `mem_din[7]` at the end of an access equals bit 7 of the written data, and `rsp_data` is that sampled byte.
- R6: If completion is not seen within TIMEOUT_CYC cycles after the hold phase, the block gives `rsp_valid` with `rsp_timeout` = 1 and returns to idle.
- R7: A read request (`req_write` = 0) holds `mem_ce_n` and `mem_oe_n` low and `mem_we_n` high for exactly ACC_CYC cycles. It then gives `rsp_valid` with `rsp_data` equal to `mem_din` sampled in the last access cycle.
- R8: `req_ready` is high only when idle. A request is taken on `req_valid` and `req_ready` both high. Changes to `poll_mode`, `req_addr` and `req_data` after acceptance have no effect on that transaction.
- R9: `mem_oe_n` is never low while `mem_we_n` is low or while `mem_drv` is high, so the bus is never driven from both sides.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Master idle, request can be taken |
| req_write | input | 1 | 1 = byte write, 0 = byte read |
| req_addr | input | AW | Byte address |
| req_data | input | 8 | Byte to write |
| poll_mode | input | 1 | Write completion method: 1 = bit-7 polling, 0 = ready/busy |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_timeout | output | 1 | Completion not seen within the limit (valid with rsp_valid) |
| rsp_data | output | 8 | Byte read, or final polled byte, or written byte in ready/busy mode |
| mem_addr | output | AW | Device address bus |
| mem_dout | output | 8 | Data driven toward the device |
| mem_drv | output | 1 | Data bus drive enable |
| mem_din | input | 8 | Data read from the device |
| mem_ce_n | output | 1 | Device select, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_rdy | input | 1 | Device ready/busy: low = programming |

## Verification
The assertions assume that `mem_rdy` and `mem_din` are already synchronous to `clk`. They also assume that a device which has taken a write eventually lowers `mem_rdy` or inverts bit 7 until programming ends. The bench meets both assumptions with a clocked memory model. On the rising edge of the strobe, the model latches the byte and holds ready/busy low for a programmable number of cycles. During that time, reads of the latched address return bit 7 inverted, and the array is updated only when the busy period ends. A stuck-busy setting of the same model drives the timeout cases, and the model is released afterwards so that the next transaction starts from an idle device.

// File: rtl/eeprom_bm_pkg.sv
package eeprom_bm_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_WSETUP,
        S_WPULSE,
        S_WHOLD,
        S_BUSY_LO,
        S_BUSY_HI,
        S_PGAP,
        S_PREAD,
        S_RACC
    } bm_state_e;

endpackage

// File: rtl/eeprom_bm_timer.sv
module eeprom_bm_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/eeprom_byte_master.sv
module eeprom_byte_master
    import eeprom_bm_pkg::*;
#(
    parameter int AW           = 13,
    parameter int SETUP_CYC    = 2,
    parameter int WE_PULSE_CYC = 4,
    parameter int HOLD_CYC     = 1,
    parameter int ACC_CYC      = 3,
    parameter int GAP_CYC      = 1,
    parameter int TIMEOUT_CYC  = 131072
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [7:0]    req_data,
    input  logic          poll_mode,
    output logic          rsp_valid,
    output logic          rsp_timeout,
    output logic [7:0]    rsp_data,
    output logic [AW-1:0] mem_addr,
    output logic [7:0]    mem_dout,
    output logic          mem_drv,
    input  logic [7:0]    mem_din,
    output logic          mem_ce_n,
    output logic          mem_we_n,
    output logic          mem_oe_n,
    input  logic          mem_rdy
);
    localparam int PH_SUM = SETUP_CYC + WE_PULSE_CYC + HOLD_CYC + ACC_CYC + GAP_CYC;
    localparam int PH_W   = $clog2(PH_SUM + 1);
    localparam int TO_W   = $clog2(TIMEOUT_CYC + 1);

    typedef struct packed {
        bm_state_e     st;
        logic [AW-1:0] addr;
        logic [7:0]    data;
        logic          poll;
        logic          ce_n;
        logic          we_n;
        logic          oe_n;
        logic          drv;
        logic          rsp_valid;
        logic          rsp_to;
        logic [7:0]    rsp_data;
    } bm_regs_t;

    bm_regs_t r_d, r_q;

    logic            ph_load, ph_exp;
    logic [PH_W-1:0] ph_val;
    logic            to_load, to_exp;
    logic            fin, fin_to;
    logic [7:0]      fin_data;

    // Phase timer: a phase loaded with N-1 occupies N cycles.
    eeprom_bm_timer #(.W(PH_W)) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ph_load),
        .load_val (ph_val),
        .expired  (ph_exp)
    );

    // Completion window timer, started when the hold phase ends.
    eeprom_bm_timer #(.W(TO_W)) u_tmo (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (to_load),
        .load_val (TO_W'(TIMEOUT_CYC - 1)),
        .expired  (to_exp)
    );

    always_comb begin
        r_d           = r_q;
        r_d.rsp_valid = 1'b0;
        ph_load       = 1'b0;
        ph_val        = '0;
        to_load       = 1'b0;
        fin           = 1'b0;
        fin_to        = 1'b0;
        fin_data      = r_q.data;

        case (r_q.st)
            S_IDLE: begin
                if (req_valid) begin
                    r_d.addr = req_addr;
                    r_d.data = req_data;
                    r_d.poll = poll_mode;
                    r_d.ce_n = 1'b0;
                    ph_load  = 1'b1;
                    if (req_write) begin
                        r_d.st  = S_WSETUP;
                        r_d.drv = 1'b1;
                        ph_val  = PH_W'(SETUP_CYC - 1);
                    end else begin
                        r_d.st   = S_RACC;
                        r_d.oe_n = 1'b0;
                        ph_val   = PH_W'(ACC_CYC - 1);
                    end
                end
            end
            S_WSETUP: begin
                if (ph_exp) begin
                    r_d.st   = S_WPULSE;
                    r_d.we_n = 1'b0;
                    ph_load  = 1'b1;
                    ph_val   = PH_W'(WE_PULSE_CYC - 1);
                end
            end
            S_WPULSE: begin
                if (ph_exp) begin
                    r_d.st   = S_WHOLD;
                    r_d.we_n = 1'b1;
                    ph_load  = 1'b1;
                    ph_val   = PH_W'(HOLD_CYC - 1);
                end
            end
            S_WHOLD: begin
                if (ph_exp) begin
                    r_d.drv = 1'b0;
                    to_load = 1'b1;
                    if (r_q.poll) begin
                        r_d.st  = S_PGAP;
                        ph_load = 1'b1;
                        ph_val  = PH_W'(GAP_CYC - 1);
                    end else begin
                        r_d.st   = S_BUSY_LO;
                        r_d.ce_n = 1'b1;
                    end
                end
            end
            S_BUSY_LO: begin
                if (!mem_rdy) begin
                    r_d.st = S_BUSY_HI;
                end else if (to_exp) begin
                    fin    = 1'b1;
                    fin_to = 1'b1;
                end
            end
            S_BUSY_HI: begin
                if (mem_rdy) begin
                    fin = 1'b1;
                end else if (to_exp) begin
                    fin    = 1'b1;
                    fin_to = 1'b1;
                end
            end
            S_PGAP: begin
                if (to_exp) begin
                    fin    = 1'b1;
                    fin_to = 1'b1;
                end else if (ph_exp) begin
                    r_d.st   = S_PREAD;
                    r_d.oe_n = 1'b0;
                    ph_load  = 1'b1;
                    ph_val   = PH_W'(ACC_CYC - 1);
                end
            end
            S_PREAD: begin
                if (ph_exp) begin
                    r_d.oe_n = 1'b1;
                    if (mem_din[7] == r_q.data[7]) begin
                        fin      = 1'b1;
                        fin_data = mem_din;
                    end else if (to_exp) begin
                        fin    = 1'b1;
                        fin_to = 1'b1;
                    end else begin
                        r_d.st  = S_PGAP;
                        ph_load = 1'b1;
                        ph_val  = PH_W'(GAP_CYC - 1);
                    end
                end
            end
            S_RACC: begin
                if (ph_exp) begin
                    fin      = 1'b1;
                    fin_data = mem_din;
                end
            end
            default: r_d.st = S_IDLE;
        endcase

        if (fin) begin
            r_d.st        = S_IDLE;
            r_d.ce_n      = 1'b1;
            r_d.oe_n      = 1'b1;
            r_d.we_n      = 1'b1;
            r_d.drv       = 1'b0;
            r_d.rsp_valid = 1'b1;
            r_d.rsp_to    = fin_to;
            r_d.rsp_data  = fin_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q           <= '0;
            r_q.st        <= S_IDLE;
            r_q.ce_n      <= 1'b1;
            r_q.we_n      <= 1'b1;
            r_q.oe_n      <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready   = (r_q.st == S_IDLE);
    assign rsp_valid   = r_q.rsp_valid;
    assign rsp_timeout = r_q.rsp_to;
    assign rsp_data    = r_q.rsp_data;
    assign mem_addr    = r_q.addr;
    assign mem_dout    = r_q.data;
    assign mem_drv     = r_q.drv;
    assign mem_ce_n    = r_q.ce_n;
    assign mem_we_n    = r_q.we_n;
    assign mem_oe_n    = r_q.oe_n;

endmodule

// File: rtl/eeprom_bm_chk.sv
module eeprom_bm_chk #(
    parameter int AW        = 13,
    parameter int SETUP_CYC = 2,
    parameter int WE_CYC    = 4,
    parameter int ACC_CYC   = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_ready,
    input logic          rsp_valid,
    input logic [AW-1:0] mem_addr,
    input logic          mem_drv,
    input logic          mem_ce_n,
    input logic          mem_we_n,
    input logic          mem_oe_n
);
    logic [15:0] we_run_q, su_run_q, oe_run_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_run_q <= '0;
            su_run_q <= '0;
            oe_run_q <= '0;
        end else begin
            we_run_q <= mem_we_n ? 16'd0 : we_run_q + 16'd1;
            oe_run_q <= mem_oe_n ? 16'd0 : oe_run_q + 16'd1;
            su_run_q <= (mem_ce_n || !mem_we_n) ? 16'd0 : su_run_q + 16'd1;
        end
    end

    a_r1_idle_deselect: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_ce_n && mem_we_n && mem_oe_n && !mem_drv));

    a_r2_ce_under_we: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_ce_n && mem_oe_n));

    a_r2_setup: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> (su_run_q >= 16'(SETUP_CYC)));

    a_r2_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n && $past(!mem_we_n)) |-> $stable(mem_addr));

    a_r2_data_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (mem_drv && !mem_ce_n));

    a_r3_we_width: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we_n && we_run_q != 16'd0) |-> (we_run_q == 16'(WE_CYC)));

    a_r5_oe_width: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_oe_n && oe_run_q != 16'd0) |-> (oe_run_q == 16'(ACC_CYC)));

    a_r4_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    a_r9_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (mem_we_n && !mem_drv));

endmodule

bind eeprom_byte_master eeprom_bm_chk #(
    .AW        (AW),
    .SETUP_CYC (SETUP_CYC),
    .WE_CYC    (WE_PULSE_CYC),
    .ACC_CYC   (ACC_CYC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .mem_addr  (mem_addr),
    .mem_drv   (mem_drv),
    .mem_ce_n  (mem_ce_n),
    .mem_we_n  (mem_we_n),
    .mem_oe_n  (mem_oe_n)
);

// File: tb/test_eeprom_byte_master.sv
module test_eeprom_byte_master;
    localparam int AW  = 4;
    localparam int SU  = 2;
    localparam int WEP = 3;
    localparam int HLD = 1;
    localparam int ACC = 2;
    localparam int GAP = 1;
    localparam int TMO = 300;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0, req_write = 1'b0, poll_mode = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [7:0]    req_data = '0;
    logic          req_ready, rsp_valid, rsp_timeout, mem_drv;
    logic [7:0]    rsp_data, mem_dout, mem_din;
    logic [AW-1:0] mem_addr;
    logic          mem_ce_n, mem_we_n, mem_oe_n, mem_rdy;

    int n_chk = 0, n_fail = 0;
    int cyc = 0;

    // device model state
    logic [7:0]    smem [16];
    logic          we_q;
    int            busy;
    int            busy_len = 4;
    logic          stuck = 1'b0;
    logic [AW-1:0] cap_addr;
    logic [7:0]    cap_data;
    int            rise_cyc;

    // pin monitor state
    int we_run = 0, last_we_w = 0, su_run = 0, last_su = 0;
    int oe_run = 0, oe_falls = 0, oe_w_err = 0, contention = 0;

    logic [7:0] model [16];

    eeprom_byte_master #(
        .AW(AW), .SETUP_CYC(SU), .WE_PULSE_CYC(WEP), .HOLD_CYC(HLD),
        .ACC_CYC(ACC), .GAP_CYC(GAP), .TIMEOUT_CYC(TMO)
    ) i_eeprom_byte_master (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_data(req_data),
        .poll_mode(poll_mode), .rsp_valid(rsp_valid), .rsp_timeout(rsp_timeout),
        .rsp_data(rsp_data), .mem_addr(mem_addr), .mem_dout(mem_dout),
        .mem_drv(mem_drv), .mem_din(mem_din), .mem_ce_n(mem_ce_n),
        .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_rdy(mem_rdy)
    );

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // busy-then-ready device model
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) smem[i] <= 8'hFF;
            we_q <= 1'b1;
            busy <= 0;
            cap_addr <= '0;
            cap_data <= '0;
            rise_cyc <= 0;
        end else begin
            we_q <= mem_we_n;
            if (!we_q && mem_we_n && !mem_ce_n) begin
                cap_addr <= mem_addr;
                cap_data <= mem_dout;
                busy     <= busy_len;
                rise_cyc <= cyc;
            end else if (busy != 0 && !stuck) begin
                if (busy == 1) smem[cap_addr] <= cap_data;
                busy <= busy - 1;
            end
        end
    end

    assign mem_rdy = (busy == 0);
    assign mem_din = (busy != 0 && mem_addr == cap_addr) ?
                     {~cap_data[7], smem[mem_addr][6:0]} : smem[mem_addr];

    // pin monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (!mem_we_n) begin
                if (we_run == 0) last_su = su_run;
                we_run++;
            end else begin
                if (we_run != 0) last_we_w = we_run;
                we_run = 0;
            end
            if (mem_ce_n || !mem_we_n) su_run = 0; else su_run++;
            if (!mem_oe_n) begin
                if (oe_run == 0) oe_falls++;
                oe_run++;
            end else begin
                if (oe_run != 0 && oe_run != ACC) oe_w_err++;
                oe_run = 0;
            end
            if (!mem_oe_n && (mem_drv || !mem_we_n)) contention++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_rsp(output bit got);
        int n = 0;
        got = 1'b0;
        while (!rsp_valid && n < 5000) begin
            @(negedge clk);
            n++;
        end
        got = rsp_valid;
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [7:0] dat, input logic pm,
                            input int blen, input logic stk);
        bit got;
        int f0, e0, el;
        busy_len = blen;
        stuck    = stk;
        f0 = oe_falls;
        e0 = oe_w_err;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_data = dat; poll_mode = pm;
        @(negedge clk);
        req_valid = 1'b0; poll_mode = ~pm; req_data = ~dat; req_addr = ~a;
        chk(req_ready == 1'b0, "R8 ready low while busy", int'(req_ready), 0);
        wait_rsp(got);
        el = cyc - rise_cyc;
        chk(got, "R4/R5 response seen", int'(got), 1);
        chk(cap_addr == a && cap_data == dat, "R2 latched address/data", int'({cap_addr, cap_data}), int'({a, dat}));
        chk(last_we_w == WEP, "R3 strobe width", last_we_w, WEP);
        chk(last_su >= SU, "R2 setup before strobe", last_su, SU);
        chk(oe_w_err == e0, "R5 access width", oe_w_err - e0, 0);
        if (stk) begin
            chk(rsp_timeout == 1'b1, "R6 timeout flag", int'(rsp_timeout), 1);
            chk(el >= TMO && el < TMO + 12, "R6 timeout latency", el, TMO);
            stuck = 1'b0;
            while (busy != 0) @(negedge clk);
            @(negedge clk);
        end else begin
            chk(rsp_timeout == 1'b0, "R4/R5 no timeout", int'(rsp_timeout), 0);
            chk(rsp_data == dat, "R4/R5 response byte", int'(rsp_data), int'(dat));
            chk(smem[a] == dat, "R4/R5 not before device done", int'(smem[a]), int'(dat));
            if (pm) chk(oe_falls - f0 >= 1, "R5 at least one status read", oe_falls - f0, 1);
            else    chk(oe_falls == f0, "R8 mode fixed at acceptance (no reads)", oe_falls - f0, 0);
            model[a] = dat;
        end
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R4 single-cycle response", int'(rsp_valid), 0);
    endtask

    task automatic do_read(input logic [AW-1:0] a);
        bit got;
        int f0, e0;
        f0 = oe_falls;
        e0 = oe_w_err;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0; req_addr = ~a;
        wait_rsp(got);
        chk(got && rsp_data == model[a], "R7 read data", int'(rsp_data), int'(model[a]));
        chk(oe_falls - f0 == 1 && oe_w_err == e0, "R7 single access of ACC cycles", oe_falls - f0, 1);
        @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) model[i] = 8'hFF;
        repeat (3) @(negedge clk);
        chk(mem_ce_n && mem_we_n && mem_oe_n && !mem_drv, "R1 pins in reset",
            int'({mem_ce_n, mem_we_n, mem_oe_n, mem_drv}), 4'b1110);
        chk(req_ready && !rsp_valid, "R1 handshake in reset", int'({req_ready, rsp_valid}), 2'b10);
        rst_n = 1'b1;
        @(negedge clk);
        chk(mem_ce_n && req_ready && !rsp_valid, "R1 idle after reset",
            int'({mem_ce_n, req_ready, rsp_valid}), 3'b110);

        for (int a = 0; a < 16; a++) begin
            for (int m = 0; m < 2; m++) begin
                do_write(AW'(a), 8'((a * 37 + m * 91 + 13) & 255), m[0], 2 + (a * 5 + m * 3) % 23, 1'b0);
            end
        end
        for (int a = 0; a < 16; a++) do_read(AW'(a));

        do_write(4'd5, 8'h80, 1'b0, 6, 1'b1);
        do_write(4'd6, 8'h01, 1'b1, 6, 1'b1);
        do_write(4'd7, 8'h7F, 1'b1, 1, 1'b0);
        do_read(4'd7);

        chk(contention == 0, "R9 no bus contention", contention, 0);

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(8 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not end, actual %0d expected 0", cyc);
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule